// File: doc/BRIEF.md
# Dithered 14-bit PWM DAC

This block turns a 14-bit control word into a rectangular waveform whose average level, after an external low-pass filter, tracks the word. Each period is 128 ticks long, and one tick is a fixed number of core clocks. The seven upper bits of the word set the coarse HIGH time in whole ticks. The seven lower bits choose how many periods out of every 128 get one extra tick of HIGH time. The chosen periods are spread across the 128-period frame by ordering them with a bit-reversed frame count.

Software loads the word through two 8-bit registers on a simple write bus: a low byte and a high byte. Writing the low byte only stages it. Writing the high byte captures both bytes as one 14-bit word and marks it pending. The pending word becomes active at the next period boundary, so no period is ever cut short. Bit 7 of the high byte decides who drives the pin. When it is 1 the modulator drives the pin. When it is 0 the pin follows a port latch bit supplied from outside.

Top module: `dith_pwm_dac`

## Requirements
- R1: After reset the high register reads 40h and the low register reads 00h. The enable is 0, so `pwm_o` equals `port_bit_i`.
- R2: Reading with `rd_sel_i`=1 returns {enable, 1, word[13:8]}. Bit 6 always reads 1, whatever was written to it. Reading with `rd_sel_i`=0 returns the last byte written to the low register.
- R3: `wr_data_i[7]` of a high-register write is the enable, and it takes effect on the cycle after the write. With the enable at 0, `pwm_o` equals `port_bit_i` in the same cycle, combinationally.
- R4: The word is {high[5:0], low[7:0]}, and coarse = word[13:7]. A tick is `TICK_DIV` clocks and a period is 128 ticks. Counting starts at reset release. With no extension, `pwm_o` is HIGH for exactly coarse ticks at the start of each period.
- R5: fine = word[6:0]. Periods are numbered from reset release, and f = period number mod 128. Period f is one tick longer when the 7-bit reversal of f is less than fine. This gives exactly fine extended periods in every 128.
- R6: Writing the low register alone never changes the output. A later high-register write commits the low byte held at the moment of that write.
- R7: A committed word becomes active only at the next period boundary. The period in progress keeps the old word.
- R8: A word of 0 gives a constant LOW. Coarse 127 in an extended period gives HIGH for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 low register, 1 high register |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 1 | Read target: 0 low register, 1 high register |
| rd_data_o | output | DATA_W | Read data, combinational |
| port_bit_i | input | 1 | Port latch bit driven to the pin while disabled |
| pwm_o | output | 1 | Pin output |

## Verification
A wrong tick or slot count shows up within one period as a HIGH count per period that differs from TICK_DIV times the coarse value. A wrong frame counter or wrong dither ordering needs up to one 128-period frame to show, as extra ticks in the wrong periods or a wrong total. A commit that arrives early shows up in the very period of the write: the HIGH count of that period mixes the old and new words. A leak from a low-register write shows up one period later. The bench therefore records the HIGH count of every period. It sweeps all coarse values, walks one full frame with a mixed fine value, and writes in mid-period to expose early commits.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } reg_sel_e;

  localparam int unsigned SLOT_BITS = 7;
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned VAL_W = 2 * DATA_W - 2,
  localparam int unsigned HI_W  = VAL_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              en_o,
  output logic [VAL_W-1:0]  stage_o,
  output logic [VAL_W-1:0]  act_o
);
  import dpwm_pkg::*;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              en_q;
  logic [VAL_W-1:0]  stage_q;
  logic [VAL_W-1:0]  act_q;
  logic              pend_q;

  logic wr_lo, wr_hi;
  assign wr_lo = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_LO);
  assign wr_hi = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
    end else if (wr_lo) begin
      lo_q <= wr_data_i;
    end
  end

  // high write snapshots the whole word; boundary commit moves it to active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      en_q    <= 1'b0;
      stage_q <= '0;
      act_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (commit_i && pend_q) begin
        act_q  <= stage_q;
        pend_q <= 1'b0;
      end
      if (wr_hi) begin
        hi_q    <= wr_data_i[HI_W-1:0];
        en_q    <= wr_data_i[DATA_W-1];
        stage_q <= {wr_data_i[HI_W-1:0], lo_q};
        pend_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    if (reg_sel_e'(rd_sel_i) == SEL_HI) rd_data_o = {en_q, 1'b1, hi_q};
    else                                rd_data_o = lo_q;
  end

  assign en_o    = en_q;
  assign stage_o = stage_q;
  assign act_o   = act_q;
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned CW       = 7,
  parameter int unsigned FW       = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] slot_o,
  output logic [FW-1:0] frame_o,
  output logic          period_end_o
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic          tick;
  logic [CW-1:0] slot_q;
  logic [FW-1:0] frame_q;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [TW-1:0] div_q;
      assign tick = (div_q == TW'(TICK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign period_end_o = tick && (slot_q == {CW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      frame_q <= '0;
    end else if (tick) begin
      slot_q <= slot_q + 1'b1;
      if (period_end_o) frame_q <= frame_q + 1'b1;
    end
  end

  assign slot_o  = slot_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/dpwm_shaper.sv
module dpwm_shaper #(
  parameter int unsigned CW = 7,
  parameter int unsigned FW = 7
) (
  input  logic [CW+FW-1:0] act_i,
  input  logic [CW-1:0]    slot_i,
  input  logic [FW-1:0]    frame_i,
  output logic             level_o
);
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;
  logic [FW-1:0] frame_rev;
  logic          ext;
  logic [CW:0]   width;

  assign coarse = act_i[CW+FW-1:FW];
  assign fine   = act_i[FW-1:0];

  // bit reversal spreads the extended periods across the frame
  generate
    for (genvar i = 0; i < FW; i++) begin : g_rev
      assign frame_rev[i] = frame_i[FW-1-i];
    end
  endgenerate

  assign ext     = (frame_rev < fine);
  assign width   = {1'b0, coarse} + {{CW{1'b0}}, ext};
  assign level_o = ({1'b0, slot_i} < width);
endmodule

// File: rtl/dith_pwm_dac.sv
module dith_pwm_dac #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TICK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              port_bit_i,
  output logic              pwm_o
);
  localparam int unsigned VAL_W = 2 * DATA_W - 2;
  localparam int unsigned CW    = VAL_W / 2;
  localparam int unsigned FW    = VAL_W - CW;

  logic             pwm_en;
  logic [VAL_W-1:0] stage_val;
  logic [VAL_W-1:0] act_val;
  logic [CW-1:0]    slot;
  logic [FW-1:0]    frame;
  logic             period_end;
  logic             level;

  dpwm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .commit_i  (period_end),
    .rd_data_o (rd_data_o),
    .en_o      (pwm_en),
    .stage_o   (stage_val),
    .act_o     (act_val)
  );

  dpwm_timebase #(.TICK_DIV(TICK_DIV), .CW(CW), .FW(FW)) u_tb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_o       (slot),
    .frame_o      (frame),
    .period_end_o (period_end)
  );

  dpwm_shaper #(.CW(CW), .FW(FW)) u_shp (
    .act_i   (act_val),
    .slot_i  (slot),
    .frame_i (frame),
    .level_o (level)
  );

  assign pwm_o = pwm_en ? level : port_bit_i;
endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned VAL_W  = 14,
  parameter int unsigned CW     = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_sel_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              port_bit_i,
  input logic              pwm_o,
  input logic              en_i,
  input logic [VAL_W-1:0]  stage_i,
  input logic [VAL_W-1:0]  act_i,
  input logic [CW-1:0]     slot_i,
  input logic              period_end_i
);
  AST_BIT6_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i |-> rd_data_o[DATA_W-2]); // R2

  AST_DISABLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && !wr_data_i[DATA_W-1]) |=> (pwm_o == port_bit_i)); // R3

  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |=> (slot_i == '0)); // R4

  AST_COARSE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (slot_i < act_i[VAL_W-1 -: CW])) |-> pwm_o); // R4

  AST_LO_NO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> $stable(stage_i)); // R6

  AST_ACT_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_i) |-> $past(period_end_i)); // R7

  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (act_i == '0)) |-> !pwm_o); // R8
endmodule

bind dith_pwm_dac dpwm_chk #(.DATA_W(DATA_W), .VAL_W(VAL_W), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .port_bit_i   (port_bit_i),
  .pwm_o        (pwm_o),
  .en_i         (pwm_en),
  .stage_i      (stage_val),
  .act_i        (act_val),
  .slot_i       (slot),
  .period_end_i (period_end)
);

// File: tb/dith_pwm_dac_tb.sv
module dith_pwm_dac_tb;
  localparam int TD  = 2;
  localparam int PER = 128 * TD;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       port_bit = 1'b0;
  logic       pwm;

  int checks = 0;
  int errs = 0;
  int edges;
  int acc = 0;
  int hist [0:1023];

  always #2 clk = ~clk;

  dith_pwm_dac #(.DATA_W(8), .TICK_DIV(TD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .port_bit_i(port_bit), .pwm_o(pwm)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) edges <= 0;
    else         edges <= edges + 1;

  // per-period HIGH sample count, state n = after n edges since release
  always @(negedge clk) begin
    if (rst_ni) begin
      if (edges % PER == PER - 1) begin
        if (edges / PER < 1024) hist[edges / PER] = acc + int'(pwm);
        acc = 0;
      end else begin
        acc = acc + int'(pwm);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_mid();
    @(negedge clk);
    while (edges % PER != PER / 2) @(negedge clk);
  endtask

  task automatic wait_done(input int p);
    @(negedge clk);
    while (edges < (p + 1) * PER + 1) @(negedge clk);
  endtask

  task automatic set_val(input logic en, input int c, input int f, output int pw);
    logic [13:0] v;
    v = 14'((c << 7) | f);
    wait_mid();
    wr(1'b0, v[7:0]);
    wr(1'b1, {en, 1'b0, v[13:8]});
    pw = edges / PER;
  endtask

  function automatic int exp_cnt(input int c, input int f, input int p);
    int fr, rev;
    fr = p % 128;
    rev = 0;
    for (int i = 0; i < 7; i++) if (fr & (1 << i)) rev |= 1 << (6 - i);
    return TD * (c + ((rev < f) ? 1 : 0));
  endfunction

  task automatic run_all();
    int pw, pw2, ext_total;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_sel = 1'b1; #1 chk("R1 hi reset", int'(rd_data), 'h40);
    rd_sel = 1'b0; #1 chk("R1 lo reset", int'(rd_data), 'h00);
    port_bit = 1'b1; #1 chk("R1 pass hi", int'(pwm), 1);
    port_bit = 1'b0; #1 chk("R1 pass lo", int'(pwm), 0);
    // R2 readback
    wr(1'b0, 8'hA5);
    rd_sel = 1'b0; #1 chk("R2 lo read", int'(rd_data), 'hA5);
    wr(1'b1, 8'h3F);
    rd_sel = 1'b1; #1 chk("R2 hi bit6 forced", int'(rd_data), 'h7F);
    wr(1'b1, 8'h00);
    #1 chk("R2 hi read", int'(rd_data), 'h40);
    // R3 disabled pin follows port bit
    port_bit = 1'b1; #1 chk("R3 disabled follows 1", int'(pwm), 1);
    port_bit = 1'b0; #1 chk("R3 disabled follows 0", int'(pwm), 0);
    // R4 / R8 coarse sweep, fine 0
    for (int c = 0; c < 128; c++) begin
      set_val(1'b1, c, 0, pw);
      wait_done(pw + 1);
      chk((c == 0) ? "R8 zero low" : "R4 coarse", hist[pw + 1], TD * c);
    end
    // R5 full frame with mixed fine value
    set_val(1'b1, 20, 37, pw);
    ext_total = 0;
    for (int k = 1; k <= 128; k++) begin
      wait_done(pw + k);
      chk("R5 period", hist[pw + k], exp_cnt(20, 37, pw + k));
      if (hist[pw + k] == TD * 21) ext_total++;
    end
    chk("R5 frame total", ext_total, 37);
    // R6 low write alone has no effect
    wait_mid();
    wr(1'b0, 8'h7F);
    pw = edges / PER;
    wait_done(pw + 2);
    chk("R6 lo only p+1", hist[pw + 1], exp_cnt(20, 37, pw + 1));
    chk("R6 lo only p+2", hist[pw + 2], exp_cnt(20, 37, pw + 2));
    wait_mid();
    wr(1'b1, 8'h8A);
    pw = edges / PER;
    wait_done(pw + 1);
    chk("R6 hi commits held lo", hist[pw + 1], exp_cnt(20, 127, pw + 1));
    // R7 commit waits for boundary
    set_val(1'b1, 10, 0, pw);
    wait_done(pw + 1);
    set_val(1'b1, 100, 0, pw2);
    wait_done(pw2 + 1);
    chk("R7 write period keeps old", hist[pw2], TD * 10);
    chk("R7 next period new", hist[pw2 + 1], TD * 100);
    // R8 full-high periods
    set_val(1'b1, 127, 127, pw);
    wait_done(pw + 2);
    chk("R8 full p+1", hist[pw + 1], exp_cnt(127, 127, pw + 1));
    chk("R8 full p+2", hist[pw + 2], exp_cnt(127, 127, pw + 2));
    // R3 disable hands pin back while a wide value is active
    wr(1'b1, 8'h3F);
    @(negedge clk);
    port_bit = 1'b0; #1 chk("R3 disable overrides pwm", int'(pwm), 0);
    port_bit = 1'b1; #1 chk("R3 disable follows port", int'(pwm), 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule